// File: doc/BRIEF.md
# Round-robin comparator channel scanner

This block steers a single analog comparator across up to eight input channels. One comparator port stays on a reference channel chosen by a 3-bit field. The other port steps through every channel whose enable bit is set. Each step is paced by a round-robin tick input. After each enabled channel has settled for a programmable number of ticks, the comparator bit is captured into that channel's result bit.

When a freshly captured bit differs from the bit stored for that channel, a sticky per-channel changed flag is set. The flags are cleared by pulsing the matching bit of a write-one-to-clear input. The interrupt output is the OR of all flags, gated by an interrupt enable. When scanning is switched on, the block first waits out an initialization delay before it selects any channel. The analog multiplexer and the reference DAC are outside the block; it only drives their select codes.

No data stream crosses the block edge. All ports are plain control and status pins, so there is no valid/ready handshake and no back-pressure: the tick and the comparator bit are sampled at clock edges, and every output is always valid.

Top module: `rr_scanner`

## Requirements
- R1: In the scan phase, the swept select visits the enabled channels in ascending order and skips channels whose `chan_en_i` bit is 0. After the highest enabled channel it wraps to the lowest enabled one. The scan phase starts on the lowest enabled channel.
- R2: A result bit whose channel is not enabled never changes.
- R3: With `fixed_minus_i`=0, `plus_sel_o` equals `fixed_ch_i` and `minus_sel_o` carries the swept channel. With `fixed_minus_i`=1, `minus_sel_o` equals `fixed_ch_i` and `plus_sel_o` carries the swept channel.
- R4: After `scan_en_i` rises, the block spends M ticks in a wait phase, where M is `init_mod_i`, or 64 when that field is 0. It takes no samples in this phase, and the swept select keeps its old value. The M-th tick enters the scan phase.
- R5: With `settle_i`=N, the channel is sampled on the (N+1)-th tick after the tick that selected it. On that same tick the sweep moves to the next channel.
- R6: A sample writes the comparator bit into `result_o[ch]` and leaves every other result bit unchanged.
- R7: A sample that differs from the stored result bit sets `changed_o[ch]`. The flag stays set until a 1 is applied on `flag_clr_i[ch]`. A sample equal to the stored bit leaves the flag clear.
- R8: `irq_o` is 1 exactly when `irq_en_i` is 1 and at least one changed flag is set.
- R9: While no channel is enabled, no sample is taken and the swept select holds its value.
- R10: While `scan_en_i` is 0, no sample is taken and the sequencer returns to the wait phase. Enabling it again applies the full R4 delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rr_tick_i | input | 1 | One-cycle round-robin tick |
| cmp_i | input | 1 | Comparator output bit |
| scan_en_i | input | 1 | Round-robin scan enable |
| irq_en_i | input | 1 | Interrupt enable |
| chan_en_i | input | 8 | Per-channel sweep enable |
| fixed_ch_i | input | 3 | Channel held on the fixed port |
| fixed_minus_i | input | 1 | 0: plus port fixed; 1: minus port fixed |
| init_mod_i | input | 6 | Initialization delay in ticks, 0 means 64 |
| settle_i | input | 2 | Settle ticks before each sample |
| flag_clr_i | input | 8 | Write-one-to-clear pulses for the changed flags |
| plus_sel_o | output | 3 | Plus-port channel select |
| minus_sel_o | output | 3 | Minus-port channel select |
| result_o | output | 8 | Last sampled result per channel |
| changed_o | output | 8 | Sticky per-channel changed flags |
| irq_o | output | 1 | Round-robin interrupt |

## Verification
The sweep is exercised with two channels that are not adjacent, so a correct skip can be told apart from plain incrementing, and the wrap back to the lowest channel is observed. The comparator bit is held equal to the stored result and then made to differ, which separates storing a result from raising a flag. Settle values 0 and 2, together with initialization moduli 3 and 0 (meaning 64), expose off-by-one errors in both counters; the bench also checks the select one tick before and at the expected transition. Scans with every channel disabled, and with the scan enable low while the comparator toggles, confirm that no sample is taken.

// File: rtl/rr_scan_pkg.sv
package rr_scan_pkg;
  typedef enum logic {
    ST_WAIT = 1'b0,
    ST_SCAN = 1'b1
  } seq_state_t;
endpackage

// File: rtl/rr_chan_picker.sv
// Combinational search for the next enabled channel after the current one
// (with wrap) and for the lowest enabled channel.
module rr_chan_picker #(
  parameter int NUM_CH = 8,
  localparam int CH_W = $clog2(NUM_CH)
) (
  input  logic [NUM_CH-1:0] en_i,
  input  logic [CH_W-1:0]   cur_i,
  output logic [CH_W-1:0]   next_o,
  output logic [CH_W-1:0]   low_o,
  output logic              any_o
);
  always_comb begin
    next_o = cur_i;
    for (int k = NUM_CH - 1; k >= 1; k--) begin
      if (en_i[(int'(cur_i) + k) % NUM_CH]) next_o = CH_W'((int'(cur_i) + k) % NUM_CH);
    end
  end

  always_comb begin
    low_o = '0;
    for (int i = NUM_CH - 1; i >= 0; i--) begin
      if (en_i[i]) low_o = CH_W'(i);
    end
  end

  assign any_o = |en_i;
endmodule

// File: rtl/rr_init_timer.sv
// Counts ticks during the wait phase; done pulses on the last one.
module rr_init_timer #(
  parameter int INIT_W = 6,
  localparam int CNT_W = INIT_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run_i,
  input  logic              tick_i,
  input  logic [INIT_W-1:0] modulus_i,
  output logic              done_o
);
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] last;

  assign last   = (modulus_i == '0) ? CNT_W'((1 << INIT_W) - 1)
                                    : CNT_W'(modulus_i) - CNT_W'(1);
  assign done_o = run_i && tick_i && (cnt_q == last);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cnt_q <= '0;
    else if (!run_i)  cnt_q <= '0;
    else if (tick_i)  cnt_q <= done_o ? '0 : cnt_q + CNT_W'(1);
  end
endmodule

// File: rtl/rr_result_bank.sv
// Per-channel result bit and sticky changed flag.
module rr_result_bank #(
  parameter int NUM_CH = 8,
  localparam int CH_W = $clog2(NUM_CH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sample_i,
  input  logic [CH_W-1:0]   ch_i,
  input  logic              cmp_i,
  input  logic [NUM_CH-1:0] clr_i,
  output logic [NUM_CH-1:0] result_o,
  output logic [NUM_CH-1:0] changed_o
);
  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    logic res_q;
    logic flg_q;
    logic hit;

    assign hit = sample_i && (ch_i == CH_W'(g));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        res_q <= 1'b0;
        flg_q <= 1'b0;
      end else begin
        if (hit) res_q <= cmp_i;
        if (hit && (cmp_i != res_q)) flg_q <= 1'b1;
        else if (clr_i[g])           flg_q <= 1'b0;
      end
    end

    assign result_o[g]  = res_q;
    assign changed_o[g] = flg_q;
  end
endmodule

// File: rtl/rr_scanner.sv
module rr_scanner #(
  parameter int NUM_CH   = 8,
  parameter int INIT_W   = 6,
  parameter int SETTLE_W = 2,
  localparam int CH_W = $clog2(NUM_CH)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                rr_tick_i,
  input  logic                cmp_i,
  input  logic                scan_en_i,
  input  logic                irq_en_i,
  input  logic [NUM_CH-1:0]   chan_en_i,
  input  logic [CH_W-1:0]     fixed_ch_i,
  input  logic                fixed_minus_i,
  input  logic [INIT_W-1:0]   init_mod_i,
  input  logic [SETTLE_W-1:0] settle_i,
  input  logic [NUM_CH-1:0]   flag_clr_i,
  output logic [CH_W-1:0]     plus_sel_o,
  output logic [CH_W-1:0]     minus_sel_o,
  output logic [NUM_CH-1:0]   result_o,
  output logic [NUM_CH-1:0]   changed_o,
  output logic                irq_o
);
  import rr_scan_pkg::*;

  seq_state_t          state_q;
  logic [CH_W-1:0]     cur_q;
  logic [SETTLE_W-1:0] dwell_q;
  logic [CH_W-1:0]     next_ch;
  logic [CH_W-1:0]     low_ch;
  logic                any_en;
  logic                init_done;
  logic                dwell_end;
  logic                sample_stb;

  rr_chan_picker #(.NUM_CH(NUM_CH)) u_picker (
    .en_i   (chan_en_i),
    .cur_i  (cur_q),
    .next_o (next_ch),
    .low_o  (low_ch),
    .any_o  (any_en)
  );

  rr_init_timer #(.INIT_W(INIT_W)) u_timer (
    .clk       (clk),
    .rst_n     (rst_n),
    .run_i     (scan_en_i && (state_q == ST_WAIT)),
    .tick_i    (rr_tick_i),
    .modulus_i (init_mod_i),
    .done_o    (init_done)
  );

  assign dwell_end  = (dwell_q >= settle_i);
  assign sample_stb = scan_en_i && rr_tick_i && (state_q == ST_SCAN)
                      && dwell_end && chan_en_i[cur_q];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_WAIT;
      cur_q   <= '0;
      dwell_q <= '0;
    end else if (!scan_en_i) begin
      state_q <= ST_WAIT;
      dwell_q <= '0;
    end else if (rr_tick_i) begin
      case (state_q)
        ST_WAIT: begin
          if (init_done) begin
            state_q <= ST_SCAN;
            cur_q   <= low_ch;
            dwell_q <= '0;
          end
        end
        default: begin
          if (dwell_end) begin
            dwell_q <= '0;
            if (any_en) cur_q <= next_ch;
          end else begin
            dwell_q <= dwell_q + SETTLE_W'(1);
          end
        end
      endcase
    end
  end

  assign plus_sel_o  = fixed_minus_i ? cur_q : fixed_ch_i;
  assign minus_sel_o = fixed_minus_i ? fixed_ch_i : cur_q;

  rr_result_bank #(.NUM_CH(NUM_CH)) u_bank (
    .clk       (clk),
    .rst_n     (rst_n),
    .sample_i  (sample_stb),
    .ch_i      (cur_q),
    .cmp_i     (cmp_i),
    .clr_i     (flag_clr_i),
    .result_o  (result_o),
    .changed_o (changed_o)
  );

  assign irq_o = irq_en_i && (|changed_o);
endmodule

// File: rtl/rr_scanner_chk.sv
module rr_scanner_chk #(
  parameter int NUM_CH   = 8,
  parameter int INIT_W   = 6,
  parameter int SETTLE_W = 2,
  localparam int CH_W = $clog2(NUM_CH)
) (
  input logic                clk,
  input logic                rst_n,
  input logic                rr_tick_i,
  input logic                cmp_i,
  input logic                scan_en_i,
  input logic                irq_en_i,
  input logic [NUM_CH-1:0]   chan_en_i,
  input logic [CH_W-1:0]     fixed_ch_i,
  input logic                fixed_minus_i,
  input logic [INIT_W-1:0]   init_mod_i,
  input logic [SETTLE_W-1:0] settle_i,
  input logic [NUM_CH-1:0]   flag_clr_i,
  input logic [CH_W-1:0]     plus_sel_o,
  input logic [CH_W-1:0]     minus_sel_o,
  input logic [NUM_CH-1:0]   result_o,
  input logic [NUM_CH-1:0]   changed_o,
  input logic                irq_o
);
  // R2: bits of channels that were disabled keep their value
  a_r2_disabled_stable: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((result_o ^ $past(result_o)) & ~$past(chan_en_i)) == '0);

  // R6: at most one result bit changes per cycle
  a_r6_one_bit: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> $countones(result_o ^ $past(result_o)) <= 1);

  // R10: no sample while scanning is off or without a tick
  a_r10_no_sample_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !(scan_en_i && rr_tick_i) |=> $stable(result_o));

  // R7: a set flag only falls when its clear bit was applied
  a_r7_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (~changed_o & $past(changed_o) & ~$past(flag_clr_i)) == '0);

  // R7: a flag only rises together with a change of its result bit
  a_r7_flag_needs_change: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (changed_o & ~$past(changed_o) & ~(result_o ^ $past(result_o))) == '0);

  // R8: no interrupt while disabled
  a_r8_irq_gated: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> irq_en_i);

  // R9: no enabled channel means no change of the swept select
  a_r9_hold_select: assert property (@(posedge clk) disable iff (!rst_n)
    (chan_en_i == '0 && $stable(fixed_minus_i) && fixed_minus_i && scan_en_i)
      |=> $stable(plus_sel_o) || !scan_en_i || $changed(fixed_minus_i) || $changed(chan_en_i));
endmodule

bind rr_scanner rr_scanner_chk #(
  .NUM_CH(NUM_CH), .INIT_W(INIT_W), .SETTLE_W(SETTLE_W)
) u_chk (.*);

// File: tb/tb_rr_scanner.sv
module tb_rr_scanner;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       rr_tick_i = 1'b0;
  logic       cmp_i = 1'b0;
  logic       scan_en_i = 1'b0;
  logic       irq_en_i = 1'b0;
  logic [7:0] chan_en_i = '0;
  logic [2:0] fixed_ch_i = '0;
  logic       fixed_minus_i = 1'b0;
  logic [5:0] init_mod_i = '0;
  logic [1:0] settle_i = '0;
  logic [7:0] flag_clr_i = '0;
  logic [2:0] plus_sel_o, minus_sel_o;
  logic [7:0] result_o, changed_o;
  logic       irq_o;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  rr_scanner dut (.*);

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk) rr_tick_i = 1'b1;
      @(negedge clk) rr_tick_i = 1'b0;
    end
  endtask

  task automatic clear_flags(input logic [7:0] m);
    @(negedge clk) flag_clr_i = m;
    @(negedge clk) flag_clr_i = '0;
  endtask

  task automatic t_reset;
    check("R6 reset result", result_o, 8'h00);
    check("R7 reset flags", changed_o, 8'h00);
    check("R8 reset irq", {7'd0, irq_o}, 8'h00);
  endtask

  task automatic t_init_delay;
    chan_en_i = 8'b0010_0100; fixed_ch_i = 3'd7; fixed_minus_i = 1'b0;
    init_mod_i = 6'd3; settle_i = 2'd0; cmp_i = 1'b1;
    @(negedge clk) scan_en_i = 1'b1;
    tick(2);
    check("R4 select held in wait", {5'd0, minus_sel_o}, 8'd0);
    check("R3 plus fixed", {5'd0, plus_sel_o}, 8'd7);
    tick(1);
    check("R1 starts at lowest enabled", {5'd0, minus_sel_o}, 8'd2);
    check("R4 no sample in wait", result_o, 8'h00);
  endtask

  task automatic t_sweep;
    cmp_i = 1'b1; tick(1);
    check("R6 ch2 sampled", result_o, 8'h04);
    check("R7 ch2 flag", changed_o, 8'h04);
    check("R1 skip to ch5", {5'd0, minus_sel_o}, 8'd5);
    cmp_i = 1'b0; tick(1);
    check("R6 ch5 equal sample", result_o, 8'h04);
    check("R1 wrap to ch2", {5'd0, minus_sel_o}, 8'd2);
    check("R2 disabled bits zero", result_o & 8'b1101_1011, 8'h00);
  endtask

  task automatic t_irq;
    #1 check("R8 irq gated off", {7'd0, irq_o}, 8'h00);
    @(negedge clk) irq_en_i = 1'b1;
    #1 check("R8 irq on", {7'd0, irq_o}, 8'h01);
    clear_flags(8'h04);
    check("R7 w1c clears", changed_o, 8'h00);
    check("R8 irq drops", {7'd0, irq_o}, 8'h00);
    check("R7 clear keeps result", result_o, 8'h04);
  endtask

  task automatic t_change_detect;
    cmp_i = 1'b1; tick(1);
    check("R7 no flag on equal", changed_o, 8'h00);
    tick(1);
    check("R7 flag on ch5 change", changed_o, 8'h20);
    check("R6 ch5 stored", result_o, 8'h24);
    check("R8 irq from ch5", {7'd0, irq_o}, 8'h01);
    clear_flags(8'h20);
  endtask

  task automatic t_settle;
    settle_i = 2'd2; cmp_i = 1'b0;
    tick(2);
    check("R5 not sampled before settle", result_o, 8'h24);
    check("R5 still on ch2", {5'd0, minus_sel_o}, 8'd2);
    tick(1);
    check("R5 sampled on third tick", result_o, 8'h20);
    check("R5 moved on", {5'd0, minus_sel_o}, 8'd5);
    clear_flags(8'h04);
    settle_i = 2'd0;
  endtask

  task automatic t_fixed_minus;
    @(negedge clk) begin fixed_minus_i = 1'b1; fixed_ch_i = 3'd4; end
    #1;
    check("R3 minus fixed", {5'd0, minus_sel_o}, 8'd4);
    check("R3 plus swept", {5'd0, plus_sel_o}, 8'd5);
  endtask

  task automatic t_disable_reinit;
    @(negedge clk) scan_en_i = 1'b0;
    cmp_i = 1'b1; tick(3);
    check("R10 no sample when off", result_o, 8'h20);
    chan_en_i = 8'h01; init_mod_i = 6'd0;
    @(negedge clk) scan_en_i = 1'b1;
    tick(63);
    check("R10 delay reapplied", {5'd0, plus_sel_o}, 8'd5);
    check("R4 no sample in 64-wait", result_o, 8'h20);
    tick(1);
    check("R4 modulus 0 means 64", {5'd0, plus_sel_o}, 8'd0);
    tick(1);
    check("R6 ch0 sampled", result_o, 8'h21);
    check("R1 single channel wraps", {5'd0, plus_sel_o}, 8'd0);
  endtask

  task automatic t_no_channel;
    clear_flags(8'h01);
    chan_en_i = 8'h00; cmp_i = 1'b0;
    tick(4);
    check("R9 no sample", result_o, 8'h21);
    check("R9 no flag", changed_o, 8'h00);
    check("R9 select holds", {5'd0, plus_sel_o}, 8'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_init_delay();
    t_sweep();
    t_irq();
    t_change_detect();
    t_settle();
    t_fixed_minus();
    t_disable_reinit();
    t_no_channel();
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule